// File: doc/BRIEF.md
# Calendar Time Counter with Tenth-Second Resolution

This block keeps wall-clock time and calendar date in BCD. It advances on a single-cycle `tick` strobe that arrives ten times per second. Each tick moves the tenths field forward, and carries ripple through seconds, minutes, hours, date, month and year in the same clock cycle. The day of week moves with the date. Month lengths are corrected, and February has 29 days in leap years. A control input selects the hour format: 24-hour, or 12-hour with a separate PM flag.

Software loads fields through a small write stream (`wr_valid`/`wr_ready`). `wr_ready` is always high, so the block never applies back-pressure. A write is accepted in every cycle where `wr_valid` is high. Every accepted write resets the tenths field to 0, so the loaded time starts on a clean boundary.

After reset the counter is frozen. Ticks are ignored until the first write is accepted. This models a cold start after loss of all supply. The tick generator is outside this block.

Top module: `cal_clock_core`

## Requirements
- R1: After reset the outputs are: tenths 0, seconds 00, minutes 00, hour 00, PM 0, day of week 0, date 01, month 01, year 00, and `running` is 0.
- R2: While no write has been accepted since reset, ticks change no time field and `running` stays 0.
- R3: A write is accepted when `wr_valid` is 1, and `wr_ready` is always 1. The select codes are:
  - 0: seconds
  - 1: minutes
  - 2: hour, with the hour value in `wr_data[5:0]` and PM in `wr_data[7]`
  - 3: day of week, from `wr_data[2:0]`
  - 4: date
  - 5: month, from `wr_data[4:0]`
  - 6: year
  - 7: no field is loaded

  Every accepted write sets `running` to 1 and clears tenths to 0. A tick in the same cycle as a write is discarded.
- R4: Tenths count 0 to 9, and the wrap from 9 to 0 advances seconds. Seconds and minutes count 00 to 59 in BCD, and each wrap carries to the next field.
- R5: In 24-hour mode (`mode_12h`=0) hours count 00 to 23. The wrap from 23 to 00 advances the date.
- R6: In 12-hour mode hours run 12, 01, …, 11.
  - The step from 11 to 12 toggles PM.
  - The step from 12 to 01 leaves PM unchanged.
  - The date advances only on the step from 11 PM to 12 AM.
- R7: Months 04, 06, 09 and 11 roll from day 30 to day 01. The other months, except February, roll from day 31 to day 01.
- R8: February rolls after day 29 when the year is divisible by 4, with 00 counted as a leap year. Otherwise it rolls after day 28.
- R9: The step past December 31 gives January 01 and increments the year. Year 99 wraps to 00.
- R10: The day of week advances with each date step and wraps from 6 to 0.
- R11: A tick seen at a clock edge is visible on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (cold start) |
| tick | input | 1 | One-cycle 10 Hz advance strobe |
| mode_12h | input | 1 | 1 selects 12-hour format with PM flag |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Always 1, no back-pressure |
| wr_sel | input | 3 | Field select (see R3) |
| wr_data | input | 8 | BCD field value |
| tenths | output | 4 | Tenths of a second, 0 to 9 |
| sec | output | 8 | Seconds, BCD |
| min | output | 8 | Minutes, BCD |
| hour | output | 6 | Hour, BCD |
| pm | output | 1 | PM flag (12-hour mode) |
| dow | output | 3 | Day of week, 0 to 6 |
| date | output | 8 | Day of month, BCD |
| month | output | 5 | Month, BCD |
| year | output | 8 | Year, BCD |
| running | output | 1 | Counter armed by a write |

## Verification
The rare cases are the calendar carries: the ends of 30-day months, February in leap and common years, and the year wrap. Reaching these by counting ticks would take weeks of simulated time. The bench instead writes a time of 23:59:59 next to the date under test. Each write clears tenths, so exactly ten ticks then cross midnight. The 12-hour cases reuse the same path with the hour written as 11 with each PM value.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_SEC   = 3'd0,
    SEL_MIN   = 3'd1,
    SEL_HOUR  = 3'd2,
    SEL_DOW   = 3'd3,
    SEL_DATE  = 3'd4,
    SEL_MONTH = 3'd5,
    SEL_YEAR  = 3'd6,
    SEL_NONE  = 3'd7
  } field_sel_e;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    if (yr[4] == 1'b0) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    else               return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] last_day(input logic [4:0] mo, input logic [7:0] yr);
    case (mo)
      5'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_bcd_counter.sv
module cal_bcd_counter #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] MIN_V = '0,
  parameter logic [W-1:0] MAX_V = '1,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] val,
  output logic         carry
);
  logic [7:0] nxt8;

  assign nxt8  = cal_pkg::bcd_inc(8'(val));
  assign carry = inc && (val >= MAX_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          val <= RST_V;
    else if (load)       val <= load_val;
    else if (inc) begin
      if (val >= MAX_V)  val <= MIN_V;
      else               val <= nxt8[W-1:0];
    end
  end

  AST_WRAP_TO_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && val >= MAX_V) |=> (val == MIN_V)); // R4
endmodule

// File: rtl/cal_hour_counter.sv
module cal_hour_counter #(
  parameter int unsigned HW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          mode_12h,
  input  logic          load,
  input  logic [HW-1:0] load_hr,
  input  logic          load_pm,
  output logic [HW-1:0] hr,
  output logic          pm,
  output logic          day_carry
);
  localparam logic [HW-1:0] H23 = HW'(8'h23);
  localparam logic [HW-1:0] H12 = HW'(8'h12);
  localparam logic [HW-1:0] H11 = HW'(8'h11);
  localparam logic [HW-1:0] H01 = HW'(8'h01);

  logic [7:0] nxt8;
  assign nxt8 = cal_pkg::bcd_inc(8'(hr));

  always_comb begin
    day_carry = 1'b0;
    if (inc) begin
      if (mode_12h) day_carry = (hr == H11) && pm;
      else          day_carry = (hr >= H23);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hr <= '0;
      pm <= 1'b0;
    end else if (load) begin
      hr <= load_hr;
      pm <= load_pm;
    end else if (inc) begin
      if (mode_12h) begin
        if (hr == H11) begin
          hr <= H12;
          pm <= ~pm;
        end else if (hr >= H12) begin
          hr <= H01;
        end else begin
          hr <= nxt8[HW-1:0];
        end
      end else begin
        if (hr >= H23) hr <= '0;
        else           hr <= nxt8[HW-1:0];
      end
    end
  end

  AST_PM_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && mode_12h && hr == H11) |=> (hr == H12 && pm != $past(pm))); // R6
  AST_24H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && !mode_12h && hr == H23) |=> (hr == '0)); // R5
endmodule

// File: rtl/cal_date_counter.sv
module cal_date_counter #(
  parameter int unsigned MW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic [MW-1:0] month,
  input  logic [7:0]    year,
  input  logic          load,
  input  logic [7:0]    load_val,
  output logic [7:0]    date,
  output logic          month_carry
);
  logic [7:0] limit;
  logic [7:0] nxt8;

  assign limit       = cal_pkg::last_day(5'(month), year);
  assign nxt8        = cal_pkg::bcd_inc(date);
  assign month_carry = inc && (date >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            date <= 8'h01;
    else if (load)         date <= load_val;
    else if (inc) begin
      if (date >= limit)   date <= 8'h01;
      else                 date <= nxt8;
    end
  end

  AST_LEAP_FEB: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && month == MW'(5'h02) && date == 8'h28 && cal_pkg::is_leap(year))
      |=> (date == 8'h29)); // R8
  AST_SHORT_MONTH: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && month == MW'(5'h04) && date == 8'h30) |=> (date == 8'h01)); // R7
endmodule

// File: rtl/cal_clock_core.sv
module cal_clock_core #(
  parameter int unsigned SEL_W = cal_pkg::SEL_W,
  parameter int unsigned DW    = 8,
  parameter int unsigned HW    = 6,
  parameter int unsigned MW    = 5,
  parameter int unsigned DOWW  = 3,
  parameter int unsigned TW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             mode_12h,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [DW-1:0]    wr_data,
  output logic [TW-1:0]    tenths,
  output logic [DW-1:0]    sec,
  output logic [DW-1:0]    min,
  output logic [HW-1:0]    hour,
  output logic             pm,
  output logic [DOWW-1:0]  dow,
  output logic [DW-1:0]    date,
  output logic [MW-1:0]    month,
  output logic [DW-1:0]    year,
  output logic             running
);
  import cal_pkg::*;

  logic wr_fire, step;
  logic c_tenths, c_sec, c_min, c_hour, c_date, c_month, c_year, c_dow;
  logic ld_sec, ld_min, ld_hour, ld_dow, ld_date, ld_month, ld_year;
  field_sel_e sel;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;
  assign step     = tick && running && !wr_fire;
  assign sel      = field_sel_e'(wr_sel);

  assign ld_sec   = wr_fire && sel == SEL_SEC;
  assign ld_min   = wr_fire && sel == SEL_MIN;
  assign ld_hour  = wr_fire && sel == SEL_HOUR;
  assign ld_dow   = wr_fire && sel == SEL_DOW;
  assign ld_date  = wr_fire && sel == SEL_DATE;
  assign ld_month = wr_fire && sel == SEL_MONTH;
  assign ld_year  = wr_fire && sel == SEL_YEAR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       running <= 1'b0;
    else if (wr_fire) running <= 1'b1;
  end

  cal_bcd_counter #(.W(TW), .MIN_V(TW'(0)), .MAX_V(TW'(9)), .RST_V(TW'(0))) u_tenths (
    .clk(clk), .rst_n(rst_n), .inc(step), .load(wr_fire), .load_val(TW'(0)),
    .val(tenths), .carry(c_tenths));

  cal_bcd_counter #(.W(DW), .MIN_V(DW'(0)), .MAX_V(DW'(8'h59)), .RST_V(DW'(0))) u_sec (
    .clk(clk), .rst_n(rst_n), .inc(c_tenths), .load(ld_sec), .load_val(wr_data),
    .val(sec), .carry(c_sec));

  cal_bcd_counter #(.W(DW), .MIN_V(DW'(0)), .MAX_V(DW'(8'h59)), .RST_V(DW'(0))) u_min (
    .clk(clk), .rst_n(rst_n), .inc(c_sec), .load(ld_min), .load_val(wr_data),
    .val(min), .carry(c_min));

  cal_hour_counter #(.HW(HW)) u_hour (
    .clk(clk), .rst_n(rst_n), .inc(c_min), .mode_12h(mode_12h), .load(ld_hour),
    .load_hr(wr_data[HW-1:0]), .load_pm(wr_data[DW-1]),
    .hr(hour), .pm(pm), .day_carry(c_hour));

  cal_bcd_counter #(.W(DOWW), .MIN_V(DOWW'(0)), .MAX_V(DOWW'(6)), .RST_V(DOWW'(0))) u_dow (
    .clk(clk), .rst_n(rst_n), .inc(c_hour), .load(ld_dow), .load_val(wr_data[DOWW-1:0]),
    .val(dow), .carry(c_dow));

  cal_date_counter #(.MW(MW)) u_date (
    .clk(clk), .rst_n(rst_n), .inc(c_hour), .month(month), .year(year),
    .load(ld_date), .load_val(wr_data), .date(date), .month_carry(c_date));

  cal_bcd_counter #(.W(MW), .MIN_V(MW'(1)), .MAX_V(MW'(5'h12)), .RST_V(MW'(1))) u_month (
    .clk(clk), .rst_n(rst_n), .inc(c_date), .load(ld_month), .load_val(wr_data[MW-1:0]),
    .val(month), .carry(c_month));

  cal_bcd_counter #(.W(DW), .MIN_V(DW'(0)), .MAX_V(DW'(8'h99)), .RST_V(DW'(0))) u_year (
    .clk(clk), .rst_n(rst_n), .inc(c_month), .load(ld_year), .load_val(wr_data),
    .val(year), .carry(c_year));

  AST_FROZEN_COLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !wr_fire) |=> ($stable(tenths) && $stable(sec) && $stable(min) && !running)); // R2
  AST_WRITE_CLEARS_TENTHS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (tenths == '0 && running)); // R3
  AST_DOW_FOLLOWS_DATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && $changed(date)) |-> ($changed(dow) || $past(wr_fire))); // R10
endmodule

// File: tb/tb_cal_clock_core.sv
module tb_cal_clock_core;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, mode_12h = 1'b0, wr_valid = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic wr_ready, pm, running;
  logic [3:0] tenths;
  logic [7:0] sec, min, date, year;
  logic [5:0] hour;
  logic [2:0] dow;
  logic [4:0] month;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  cal_clock_core dut (.clk(clk), .rst_n(rst_n), .tick(tick), .mode_12h(mode_12h),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_sel(wr_sel), .wr_data(wr_data),
    .tenths(tenths), .sec(sec), .min(min), .hour(hour), .pm(pm), .dow(dow),
    .date(date), .month(month), .year(year), .running(running));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_date(input logic [7:0] y, input logic [4:0] m, input logic [7:0] d);
    wr(3'd6, y); wr(3'd5, {3'b0, m}); wr(3'd4, d);
  endtask

  task automatic cross_midnight(input logic [7:0] hr_w);
    wr(3'd2, hr_w); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    ticks(10);
  endtask

  task automatic t_reset;
    chk("R1 tenths", tenths, 0); chk("R1 sec", sec, 0); chk("R1 hour", hour, 0);
    chk("R1 pm", pm, 0); chk("R1 date", date, 1); chk("R1 month", month, 1);
    chk("R1 year", year, 0); chk("R1 dow", dow, 0); chk("R1 running", running, 0);
  endtask

  task automatic t_frozen;
    ticks(15);
    chk("R2 tenths", tenths, 0); chk("R2 sec", sec, 0); chk("R2 running", running, 0);
  endtask

  task automatic t_write;
    chk("R3 ready", wr_ready, 1);
    wr(3'd0, 8'h58);
    chk("R3 sec", sec, 8'h58); chk("R3 running", running, 1);
    ticks(3);
    chk("R11 tenths", tenths, 3);
    wr(3'd7, 8'hFF);
    chk("R3 sel7 tenths", tenths, 0); chk("R3 sel7 sec", sec, 8'h58);
    chk("R3 sel7 min", min, 0); chk("R3 sel7 year", year, 0);
    @(negedge clk); wr_valid = 1'b1; wr_sel = 3'd1; wr_data = 8'h07; tick = 1'b1;
    @(negedge clk); wr_valid = 1'b0; tick = 1'b0;
    chk("R3 collide tenths", tenths, 0); chk("R3 collide min", min, 8'h07);
  endtask

  task automatic t_tenths;
    wr(3'd0, 8'h58); wr(3'd1, 8'h00);
    ticks(9);
    chk("R4 tenths9", tenths, 9); chk("R4 sec hold", sec, 8'h58);
    ticks(1);
    chk("R4 tenths wrap", tenths, 0); chk("R4 sec", sec, 8'h59);
    ticks(10);
    chk("R4 sec wrap", sec, 0); chk("R4 min", min, 8'h01);
  endtask

  task automatic t_24h;
    mode_12h = 1'b0;
    set_date(8'h25, 5'h03, 8'h10); wr(3'd3, 8'h02);
    cross_midnight(8'h23);
    chk("R5 hour", hour, 0); chk("R5 date", date, 8'h11); chk("R10 dow", dow, 3);
    wr(3'd3, 8'h06); cross_midnight(8'h23);
    chk("R10 dow wrap", dow, 0);
    wr(3'd2, 8'h09); wr(3'd1, 8'h59); wr(3'd0, 8'h59); ticks(10);
    chk("R5 hour 9to10", hour, 8'h10);
  endtask

  task automatic t_12h;
    mode_12h = 1'b1;
    set_date(8'h25, 5'h03, 8'h10);
    cross_midnight(8'h11);
    chk("R6 11am hour", hour, 8'h12); chk("R6 11am pm", pm, 1); chk("R6 11am date", date, 8'h10);
    cross_midnight(8'h12 | 8'h80);
    chk("R6 12pm hour", hour, 8'h01); chk("R6 12pm pm", pm, 1);
    cross_midnight(8'h11 | 8'h80);
    chk("R6 11pm hour", hour, 8'h12); chk("R6 11pm pm", pm, 0); chk("R6 11pm date", date, 8'h11);
    mode_12h = 1'b0;
  endtask

  task automatic t_months;
    set_date(8'h25, 5'h04, 8'h30); cross_midnight(8'h23);
    chk("R7 apr date", date, 1); chk("R7 apr month", month, 5'h05);
    set_date(8'h25, 5'h05, 8'h30); cross_midnight(8'h23);
    chk("R7 may30", date, 8'h31); chk("R7 may month", month, 5'h05);
    set_date(8'h25, 5'h11, 8'h30); cross_midnight(8'h23);
    chk("R7 nov month", month, 5'h12);
  endtask

  task automatic t_feb;
    set_date(8'h24, 5'h02, 8'h28); cross_midnight(8'h23);
    chk("R8 leap24", date, 8'h29);
    cross_midnight(8'h23);
    chk("R8 leap24 roll", month, 5'h03);
    set_date(8'h23, 5'h02, 8'h28); cross_midnight(8'h23);
    chk("R8 common date", date, 1); chk("R8 common month", month, 5'h03);
    set_date(8'h00, 5'h02, 8'h28); cross_midnight(8'h23);
    chk("R8 leap00", date, 8'h29);
    set_date(8'h12, 5'h02, 8'h28); cross_midnight(8'h23);
    chk("R8 leap12", date, 8'h29);
  endtask

  task automatic t_year;
    set_date(8'h99, 5'h12, 8'h31); cross_midnight(8'h23);
    chk("R9 date", date, 1); chk("R9 month", month, 1); chk("R9 year", year, 0);
    set_date(8'h19, 5'h12, 8'h31); cross_midnight(8'h23);
    chk("R9 year inc", year, 8'h20);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frozen();
    t_write();
    t_tenths();
    t_24h();
    t_12h();
    t_months();
    t_feb();
    t_year();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule